// File: doc/BRIEF.md
# Command/Response FIFO Sequencer

This block is the device-side sequencer that sits behind a byte-wide data port and a status register in a host-visible register window. The host pushes a command as a stream of bytes into the data port, tells the block to start, and later pulls the response out of the same data port. The block keeps the command bytes in a local buffer and reads the total command length from its header. From that length it decides how long the "more data expected" flag stays up. Throughout the exchange it reports a 16-bit burst count, so the host knows how many bytes it may move without polling again.

On the device side, a simple backend handshake is used. A one-cycle start pulse announces a complete command, and the backend reads the stored command bytes by index. The backend then returns response bytes one per cycle with a valid strobe and ends the response with a done strobe. A host write of the command-ready bit aborts whatever is in progress from any state and emits an abort pulse toward the backend. The register port is assumed to carry only accesses from the locality that currently owns the device. Arbitration between localities and interrupt generation are handled elsewhere.

Top module: `cmd_rsp_seq`

## Requirements
- R1: After reset the status byte (offset 0x18) reads 0xC0, the burst count reads 64 (offset 0x19 = 0x40, offset 0x1A = 0x00), and neither backend pulse is high.
- R2: Status byte layout: bit 7 valid (always 1), bit 6 command ready (1 only in the ready state), bit 5 go (always reads 0), bit 4 data available, bit 3 data expected, bits 2..0 zero. The burst count is 16 bits, with the low byte at 0x19 and the high byte at 0x1A. The data port is at 0x24. Any other offset reads 0x00.
- R3: Data-port writes in the ready state, or in the receive state while data expected is set, are stored in order. The first such write moves the block to the receive state. Data expected is set while fewer than 10 bytes are stored, or while fewer bytes are stored than the length in header bytes 2..5 (big-endian, byte 2 most significant).
- R4: Data expected clears when the stored count reaches the target. The target is the declared length, raised to at least 10 and capped at 64. After that, further data-port writes are dropped.
- R5: The burst count equals the free command space (64 minus stored bytes) in the ready and receive states. It is 0 while executing. It equals the number of unread response bytes in the complete state.
- R6: Writing status bit 5 in the receive state with data expected clear has three effects. The start pulse goes high for one cycle in the next cycle. The block enters the execute state, where the status reads 0x80. The backend sees the stored byte count and the stored bytes at any index.
- R7: A go write is ignored while data expected is set, and in the ready, execute and complete states.
- R8: While executing, each backend valid byte is stored, up to 64 bytes, and excess bytes are dropped. A done strobe moves the block to the complete state.
- R9: In the complete state, data-port reads return response bytes in arrival order. Data available clears after the last byte has been read. Reads with no data available return 0xFF and consume nothing.
- R10: Writing status bit 6 aborts from any state. The block returns to ready with empty buffers and pulses the abort output for one cycle. Abort takes priority over a simultaneous go.
- R11: Data-port writes in the execute and complete states are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset in the window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| be_start | output | 1 | One-cycle command start pulse |
| be_abort | output | 1 | One-cycle abort pulse |
| be_cmd_len | output | 7 | Number of stored command bytes |
| be_cmd_idx | input | 6 | Command byte index from backend |
| be_cmd_byte | output | 8 | Command byte at be_cmd_idx |
| be_rsp_valid | input | 1 | Response byte strobe |
| be_rsp_data | input | 8 | Response byte |
| be_rsp_done | input | 1 | End of response |

## Verification
The hardest conditions to reach are the boundaries of the expected flag. These are a declared length below the header size, a length exactly at the buffer depth, and a length past it, where the cap rather than the header ends reception. The bench sweeps declared lengths from 0 through 17 and adds 40, 64 and 100. After every byte it checks the flag and the free count against the arithmetic target. It also tries go too early, overfills the response side with 70 bytes, and aborts inside execution and together with go.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int ADDR_W   = 12;
  localparam int HDR_LEN  = 10;
  localparam logic [ADDR_W-1:0] STS_OFS  = 12'h018;
  localparam logic [ADDR_W-1:0] FIFO_OFS = 12'h024;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_RECV  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cmdseq_buf.sv
module cmdseq_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cmdseq_regif.sv
module cmdseq_regif
  import cmdseq_pkg::*;
(
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wbit_abort,
  input  logic              wbit_go,
  input  logic              flag_ready,
  input  logic              flag_avail,
  input  logic              flag_expect,
  input  logic [15:0]       burst,
  input  logic [7:0]        fifo_data,
  output logic              fifo_wr,
  output logic              fifo_rd,
  output logic              abort_req,
  output logic              go_req,
  output logic [7:0]        rdata
);
  logic sts_hit, fifo_hit;

  assign sts_hit   = (reg_addr == STS_OFS);
  assign fifo_hit  = (reg_addr == FIFO_OFS);
  assign fifo_wr   = reg_wr && fifo_hit;
  assign fifo_rd   = reg_rd && fifo_hit;
  assign abort_req = reg_wr && sts_hit && wbit_abort;
  assign go_req    = reg_wr && sts_hit && wbit_go && !wbit_abort;

  always_comb begin
    rdata = 8'h00;
    if (sts_hit) begin
      rdata = {1'b1, flag_ready, 1'b0, flag_avail, flag_expect, 3'b000};
    end else if (reg_addr == STS_OFS + 12'd1) begin
      rdata = burst[7:0];
    end else if (reg_addr == STS_OFS + 12'd2) begin
      rdata = burst[15:8];
    end else if (fifo_hit) begin
      rdata = flag_avail ? fifo_data : 8'hFF;
    end
  end
endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
  import cmdseq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_wr,
  input  logic             fifo_rd,
  input  logic             abort_req,
  input  logic             go_req,
  input  logic [7:0]       fifo_wdata,
  input  logic             rsp_valid,
  input  logic             rsp_done,
  output logic             cmd_we,
  output logic [CNT_W-1:0] cmd_cnt,
  output logic             rsp_we,
  output logic [CNT_W-1:0] rsp_cnt,
  output logic [CNT_W-1:0] rd_ptr,
  output logic             flag_ready,
  output logic             flag_expect,
  output logic             flag_avail,
  output logic [15:0]      burst,
  output logic             start_pulse,
  output logic             abort_pulse
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR_LEN);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cmd_cnt_d, rsp_cnt_d, rd_ptr_d;
  logic [31:0]      decl_len_q, decl_len_d;
  logic [CNT_W-1:0] target_len;
  logic             go_accept, rsp_pop;
  logic             cnt_en, len_en, rsp_en, rd_en, st_en;

  // Target byte count: declared length clamped to [HDR_LEN, DEPTH]
  always_comb begin
    if (decl_len_q > 32'(DEPTH))        target_len = DEPTH_C;
    else if (decl_len_q < 32'(HDR_LEN)) target_len = HDR_C;
    else                                target_len = decl_len_q[CNT_W-1:0];
  end

  assign flag_ready  = (state_q == ST_READY);
  assign flag_expect = (state_q == ST_RECV) &&
                       ((cmd_cnt < HDR_C) || (cmd_cnt < target_len));
  assign flag_avail  = (state_q == ST_DONE) && (rd_ptr < rsp_cnt);

  assign cmd_we    = fifo_wr && ((state_q == ST_READY) || flag_expect);
  assign go_accept = go_req && (state_q == ST_RECV) && !flag_expect;
  assign rsp_we    = rsp_valid && (state_q == ST_EXEC) && (rsp_cnt < DEPTH_C);
  assign rsp_pop   = fifo_rd && flag_avail;

  always_comb begin
    case (state_q)
      ST_READY, ST_RECV: burst = 16'(DEPTH_C - cmd_cnt);
      ST_DONE:           burst = 16'(rsp_cnt - rd_ptr);
      default:           burst = 16'd0;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    if (abort_req) begin
      state_d = ST_READY;
    end else begin
      case (state_q)
        ST_READY: if (cmd_we)    state_d = ST_RECV;
        ST_RECV:  if (go_accept) state_d = ST_EXEC;
        ST_EXEC:  if (rsp_done)  state_d = ST_DONE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_comb begin
    cmd_cnt_d  = abort_req ? '0 : cmd_cnt + 1'b1;
    decl_len_d = abort_req ? '0 : {decl_len_q[23:0], fifo_wdata};
    rsp_cnt_d  = (abort_req || go_accept) ? '0 : rsp_cnt + 1'b1;
    rd_ptr_d   = (abort_req || go_accept) ? '0 : rd_ptr + 1'b1;
  end

  // Clock enables
  assign st_en  = (state_d != state_q);
  assign cnt_en = abort_req || cmd_we;
  assign len_en = abort_req ||
                  (cmd_we && (cmd_cnt >= CNT_W'(2)) && (cmd_cnt <= CNT_W'(5)));
  assign rsp_en = abort_req || go_accept || rsp_we;
  assign rd_en  = abort_req || go_accept || rsp_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_READY;
      cmd_cnt     <= '0;
      decl_len_q  <= '0;
      rsp_cnt     <= '0;
      rd_ptr      <= '0;
      start_pulse <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      if (st_en)  state_q    <= state_d;
      if (cnt_en) cmd_cnt    <= cmd_cnt_d;
      if (len_en) decl_len_q <= decl_len_d;
      if (rsp_en) rsp_cnt    <= rsp_cnt_d;
      if (rd_en)  rd_ptr     <= rd_ptr_d;
      start_pulse <= go_accept;
      abort_pulse <= abort_req;
    end
  end

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_expect && flag_avail));
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cnt <= DEPTH_C) && (rsp_cnt <= DEPTH_C));
  p_go_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept |=> (state_q == ST_EXEC) && start_pulse);
  p_go_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && flag_expect) |=> (state_q == ST_RECV) && !start_pulse);
  p_last_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_pop && (rd_ptr + 1'b1 == rsp_cnt)) |=> !flag_avail);
  p_abort_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (state_q == ST_READY) && (cmd_cnt == '0) && (rsp_cnt == '0) && abort_pulse);
  p_drop_late_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && ((state_q == ST_EXEC) || (state_q == ST_DONE))) |=> $stable(cmd_cnt));
endmodule

// File: rtl/cmd_rsp_seq.sv
module cmd_rsp_seq
  import cmdseq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              be_start,
  output logic              be_abort,
  output logic [CNT_W-1:0]  be_cmd_len,
  input  logic [AW-1:0]     be_cmd_idx,
  output logic [7:0]        be_cmd_byte,
  input  logic              be_rsp_valid,
  input  logic [7:0]        be_rsp_data,
  input  logic              be_rsp_done
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             fifo_wr, fifo_rd, abort_req, go_req;
  logic             cmd_we, rsp_we;
  logic [CNT_W-1:0] cmd_cnt, rsp_cnt, rd_ptr;
  logic             flag_ready, flag_expect, flag_avail;
  logic [15:0]      burst;
  logic [7:0]       rsp_rdata;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cmdseq_regif u_regif (
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .wbit_abort  (reg_wdata[6]),
    .wbit_go     (reg_wdata[5]),
    .flag_ready  (flag_ready),
    .flag_avail  (flag_avail),
    .flag_expect (flag_expect),
    .burst       (burst),
    .fifo_data   (rsp_rdata),
    .fifo_wr     (fifo_wr),
    .fifo_rd     (fifo_rd),
    .abort_req   (abort_req),
    .go_req      (go_req),
    .rdata       (reg_rdata)
  );

  cmdseq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fifo_wr     (fifo_wr),
    .fifo_rd     (fifo_rd),
    .abort_req   (abort_req),
    .go_req      (go_req),
    .fifo_wdata  (reg_wdata),
    .rsp_valid   (be_rsp_valid),
    .rsp_done    (be_rsp_done),
    .cmd_we      (cmd_we),
    .cmd_cnt     (cmd_cnt),
    .rsp_we      (rsp_we),
    .rsp_cnt     (rsp_cnt),
    .rd_ptr      (rd_ptr),
    .flag_ready  (flag_ready),
    .flag_expect (flag_expect),
    .flag_avail  (flag_avail),
    .burst       (burst),
    .start_pulse (be_start),
    .abort_pulse (be_abort)
  );

  cmdseq_buf #(.DEPTH(DEPTH), .AW(AW)) u_cmd_buf (
    .clk   (clk),
    .we    (cmd_we),
    .waddr (cmd_cnt[AW-1:0]),
    .wdata (reg_wdata),
    .raddr (be_cmd_idx),
    .rdata (be_cmd_byte)
  );

  cmdseq_buf #(.DEPTH(DEPTH), .AW(AW)) u_rsp_buf (
    .clk   (clk),
    .we    (rsp_we),
    .waddr (rsp_cnt[AW-1:0]),
    .wdata (be_rsp_data),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (rsp_rdata)
  );

  assign be_cmd_len = cmd_cnt;
endmodule

// File: tb/cmd_rsp_seq_tb.sv
module cmd_rsp_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        be_start, be_abort;
  logic [6:0]  be_cmd_len;
  logic [5:0]  be_cmd_idx;
  logic [7:0]  be_cmd_byte;
  logic        be_rsp_valid, be_rsp_done;
  logic [7:0]  be_rsp_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] rv;

  localparam logic [11:0] A_STS = 12'h018, A_BLO = 12'h019, A_BHI = 12'h01A, A_FIFO = 12'h024;

  always #5 clk = ~clk;

  cmd_rsp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .be_start(be_start), .be_abort(be_abort), .be_cmd_len(be_cmd_len),
    .be_cmd_idx(be_cmd_idx), .be_cmd_byte(be_cmd_byte),
    .be_rsp_valid(be_rsp_valid), .be_rsp_data(be_rsp_data), .be_rsp_done(be_rsp_done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    be_rsp_valid = 1'b1; be_rsp_data = d;
    @(negedge clk);
    be_rsp_valid = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    be_rsp_done = 1'b1;
    @(negedge clk);
    be_rsp_done = 1'b0;
  endtask

  task automatic chk_burst(input string tag, input int exp);
    logic [7:0] lo, hi;
    rd(A_BLO, lo);
    rd(A_BHI, hi);
    chk(tag, {hi, lo}, exp);
  endtask

  function automatic logic [7:0] cmd_byte(input int k, input int L);
    if (k >= 2 && k <= 5) return 8'((L >> (8 * (5 - k))) & 255);
    return 8'((k * 5 + L + 1) & 255);
  endfunction

  // Fill a command of declared length L up to its target
  task automatic fill_cmd(input int L, input int tgt);
    for (int k = 0; k < tgt; k++) wr(A_FIFO, cmd_byte(k, L));
  endtask

  int lens[21] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,17,40,64,100};

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    be_cmd_idx = 0; be_rsp_valid = 0; be_rsp_data = 0; be_rsp_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_STS, rv); chk("R1 status", rv, 8'hC0);
    chk_burst("R1 burst", 64);
    chk("R1 start low", be_start, 0);
    chk("R1 abort low", be_abort, 0);
    // R2 unmapped offset
    rd(12'h000, rv); chk("R2 unmapped reads zero", rv, 0);
    // R7 go in ready ignored
    wr(A_STS, 8'h20);
    chk("R7 go in ready no start", be_start, 0);
    rd(A_STS, rv); chk("R7 go in ready status", rv, 8'hC0);

    foreach (lens[li]) begin
      int L, tgt, rl, nst;
      L = lens[li];
      tgt = (L < 10) ? 10 : (L > 64 ? 64 : L);
      rl = (L == 100) ? 70 : ((L * 3) % 20 + 1);
      nst = (rl > 64) ? 64 : rl;

      wr(A_STS, 8'h40);
      chk("R10 abort pulse", be_abort, 1);
      rd(A_STS, rv); chk("R10 status after abort", rv, 8'hC0);

      for (int k = 0; k < tgt; k++) begin
        wr(A_FIFO, cmd_byte(k, L));
        rd(A_STS, rv);
        chk("R3 expect flag per byte", rv, (k + 1 < tgt) ? 8'h88 : 8'h80);
        chk_burst("R5 free space", 64 - (k + 1));
        if (k == 0) begin
          wr(A_STS, 8'h20);
          chk("R7 go while expect no start", be_start, 0);
          rd(A_STS, rv); chk("R7 go while expect status", rv, 8'h88);
        end
      end
      // R4 extra write dropped
      wr(A_FIFO, 8'hA5);
      chk_burst("R4 extra write dropped", 64 - tgt);

      // R6 go
      wr(A_STS, 8'h20);
      chk("R6 start pulse", be_start, 1);
      @(negedge clk);
      chk("R6 start one cycle", be_start, 0);
      rd(A_STS, rv); chk("R6 exec status", rv, 8'h80);
      chk_burst("R5 exec burst zero", 0);
      chk("R6 cmd len", be_cmd_len, tgt);
      for (int k = 0; k < tgt; k++) begin
        be_cmd_idx = 6'(k);
        #1 chk("R6 cmd byte", be_cmd_byte, cmd_byte(k, L));
      end
      // R11 write during execute dropped
      wr(A_FIFO, 8'h5A);
      chk("R11 exec write dropped", be_cmd_len, tgt);
      wr(A_STS, 8'h20);
      chk("R7 go in exec ignored", be_start, 0);

      // R8 response
      for (int i = 0; i < rl; i++) push(8'((i * 11 + L) & 255));
      done();
      rd(A_STS, rv); chk("R8 complete status", rv, 8'h90);
      chk_burst("R8 stored count", nst);

      // R9 read out
      for (int i = 0; i < nst; i++) begin
        rd(A_FIFO, rv); chk("R9 response byte", rv, (i * 11 + L) & 255);
      end
      rd(A_STS, rv); chk("R9 avail cleared", rv, 8'h80);
      rd(A_FIFO, rv); chk("R9 empty read 0xFF", rv, 8'hFF);
      chk_burst("R5 burst after drain", 0);
      // R11 write in complete dropped
      wr(A_FIFO, 8'h33);
      rd(A_STS, rv); chk("R11 complete write dropped", rv, 8'h80);
    end

    // R10 abort during execute
    wr(A_STS, 8'h40);
    fill_cmd(10, 10);
    wr(A_STS, 8'h20);
    push(8'h11); push(8'h22);
    wr(A_STS, 8'h40);
    chk("R10 abort in exec pulse", be_abort, 1);
    rd(A_STS, rv); chk("R10 abort in exec status", rv, 8'hC0);
    chk_burst("R10 abort clears buffer", 64);

    // R10 abort wins over go
    fill_cmd(12, 12);
    wr(A_STS, 8'h60);
    chk("R10 abort beats go start", be_start, 0);
    chk("R10 abort beats go pulse", be_abort, 1);
    rd(A_STS, rv); chk("R10 abort beats go status", rv, 8'hC0);

    // R9 read in ready returns 0xFF
    rd(A_FIFO, rv); chk("R9 read in ready", rv, 8'hFF);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule